// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives a host processor access to a small file of 8-bit delay settings that sit behind a PHY. The host does not address these settings directly. It reaches them through one 32-bit control word placed in a 1 KB register window. The host loads a PHY address and a data byte into the word. It then raises a write or read request bit and keeps it raised. The block carries out the access on the PHY side after a configurable number of cycles, and it answers by setting an acknowledge bit. The host sees the acknowledge, lowers the request, and the block lowers the acknowledge in turn. This closes a full four-phase handshake.

On a read, the addressed setting is returned in a read-only byte of the same control word. It stays there until the next read completes. The PHY side implements twelve settings: nine input-delay entries for the different bus speed modes at addresses 0x00 to 0x08, and three clock and strobe delay-line settings at 0x0B, 0x0C and 0x0D. All other addresses still complete the handshake, but they hold no storage.

Top module: `phy_port_bridge`

## Requirements
- R1: The control word answers only at byte offset 0x10 of the window. A read of any other offset (for example 0x14 or 0x200) returns 0, and a write there leaves the control word unchanged.
- R2: The control word has these fields: PHY address in bits 7:0, write byte in bits 15:8, read-back byte in bits 23:16 (read-only), write request in bit 24, read request in bit 25, acknowledge in bit 26 (read-only). Bits 31:27 read as 0.
- R3: The acknowledge rises exactly LATENCY+1 clock edges after the edge that stored a request bit. With the default LATENCY of 3, that is 4 edges. The acknowledge then stays high for as long as either request bit stays set.
- R4: Once both request bits are clear, the acknowledge is 0 after the second clock edge that follows the clearing write.
- R5: Each request performs exactly one PHY access. Holding the write request after the acknowledge, even with a new write byte, changes no PHY setting. No new access starts until the acknowledge has returned to 0.
- R6: A read places the addressed setting in the read-back byte no later than the cycle in which the acknowledge rises. The byte keeps that value through later writes until the next read completes.
- R7: A write to an implemented address (0x00 to 0x08, 0x0B, 0x0C, 0x0D) stores the write byte, and a later read of that address returns it.
- R8: Accesses to unimplemented addresses (0x09, 0x0A, 0x0E to 0xFF) complete the handshake with the same timing. Writes to them are discarded, and reads of them return 0.
- R9: If the write and read request bits are set together, the block performs a write and leaves the read-back byte unchanged.
- R10: After reset the control word reads 0, and every PHY setting reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select for this window |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | BUS_AW (10) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |

## Verification
The hardest case to reach from the ports is a request that is still held after its acknowledge, while the host changes the data field under it. The bench can only show that no second access happened by reading the setting back later through a separate handshake. To get there, the stimulus splits the access into start, wait and release steps. Between the wait and the release, it writes the control word again with the write request still set and a different byte, holds that for several cycles, and then releases. A scoreboard queue receives the expected read-back byte before every read. A monitor compares the byte at the exact cycle where the acknowledge rises, so it also catches a byte that arrives late.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
   localparam int PORT_W      = 32;
   localparam int FLD_W       = 8;
   localparam int LSB_ADDR    = 0;
   localparam int LSB_WBYTE   = 8;
   localparam int LSB_RBYTE   = 16;
   localparam int BIT_WREQ    = 24;
   localparam int BIT_RREQ    = 25;
   localparam int BIT_ACK     = 26;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_DONE = 2'd2
   } hs_state_e;

   typedef struct packed {
      logic             rreq;
      logic             wreq;
      logic [FLD_W-1:0] wbyte;
      logic [FLD_W-1:0] paddr;
   } port_ctl_t;
endpackage

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
   import phy_port_pkg::*;
#(
   parameter int               BUS_AW      = 10,
   parameter logic [BUS_AW-1:0] PORT_OFFSET = 10'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic              hit,
   output port_ctl_t         ctl
);
   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[PORT_W-1:BIT_ACK], bus_wdata[LSB_RBYTE +: FLD_W]};

   assign hit = bus_sel && (bus_addr == PORT_OFFSET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (hit && bus_wr) begin
         ctl.paddr <= bus_wdata[LSB_ADDR  +: FLD_W];
         ctl.wbyte <= bus_wdata[LSB_WBYTE +: FLD_W];
         ctl.wreq  <= bus_wdata[BIT_WREQ];
         ctl.rreq  <= bus_wdata[BIT_RREQ];
      end
   end
endmodule

// File: rtl/hs_seq.sv
module hs_seq
   import phy_port_pkg::*;
#(
   parameter int LATENCY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   input  logic req_rd,
   output logic ack,
   output logic phy_we,
   output logic rd_cap
);
   localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

   hs_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             op_wr_q;
   logic             last;

   assign last   = (state_q == HS_WAIT) && (cnt_q == CNT_LAST);
   assign phy_we = last && op_wr_q;
   assign rd_cap = last && !op_wr_q;
   assign ack    = (state_q == HS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         cnt_q   <= '0;
         op_wr_q <= 1'b0;
      end else begin
         unique case (state_q)
            HS_IDLE: if (req_wr || req_rd) begin
               state_q <= HS_WAIT;
               cnt_q   <= '0;
               op_wr_q <= req_wr;
            end
            HS_WAIT: if (last) state_q <= HS_DONE;
                     else      cnt_q   <= cnt_q + 1'b1;
            HS_DONE: if (!req_wr && !req_rd) state_q <= HS_IDLE;
            default: state_q <= HS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/phy_delay_file.sv
module phy_delay_file #(
   parameter int                 AW        = 8,
   parameter int                 DW        = 8,
   parameter int                 NUM_SLOTS = 14,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = 14'h39FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] slot_q [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (IMPL_MASK[g]) begin : g_impl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        slot_q[g] <= '0;
            else if (we && addr == AW'(g))     slot_q[g] <= wdata;
         end
      end else begin : g_hole
         assign slot_q[g] = '0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (addr == AW'(i)) rdata = slot_q[i];
      end
   end
endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
   import phy_port_pkg::*;
#(
   parameter int                 BUS_AW      = 10,
   parameter logic [BUS_AW-1:0]  PORT_OFFSET = 10'h010,
   parameter int                 LATENCY     = 3,
   parameter int                 NUM_SLOTS   = 14,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = 14'h39FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam int TOP_PAD = PORT_W - BIT_ACK - 1;

   if (LATENCY < 1 || LATENCY > 8) begin : g_bad_latency
      $error("phy_port_bridge: LATENCY must lie in 1..8");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << FLD_W)) begin : g_bad_slots
      $error("phy_port_bridge: NUM_SLOTS out of range");
   end
   if (PORT_OFFSET[1:0] != 2'b00) begin : g_bad_offset
      $error("phy_port_bridge: PORT_OFFSET must be word aligned");
   end

   logic             port_hit;
   port_ctl_t        port_ctl;
   logic             ack;
   logic             phy_we;
   logic             rd_cap;
   logic [FLD_W-1:0] phy_rdata;
   logic [FLD_W-1:0] rbyte_q;

   port_ctl_reg #(.BUS_AW(BUS_AW), .PORT_OFFSET(PORT_OFFSET)) u_ctl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hit(port_hit), .ctl(port_ctl)
   );

   hs_seq #(.LATENCY(LATENCY)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_wr(port_ctl.wreq), .req_rd(port_ctl.rreq),
      .ack(ack), .phy_we(phy_we), .rd_cap(rd_cap)
   );

   phy_delay_file #(.AW(FLD_W), .DW(FLD_W), .NUM_SLOTS(NUM_SLOTS), .IMPL_MASK(IMPL_MASK)) u_file (
      .clk(clk), .rst_n(rst_n), .we(phy_we), .addr(port_ctl.paddr),
      .wdata(port_ctl.wbyte), .rdata(phy_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rbyte_q <= '0;
      else if (rd_cap) rbyte_q <= phy_rdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (port_hit && !bus_wr) begin
         bus_rdata = {{TOP_PAD{1'b0}}, ack, port_ctl.rreq, port_ctl.wreq,
                      rbyte_q, port_ctl.wbyte, port_ctl.paddr};
      end
   end
endmodule

// File: rtl/phy_port_chk.sv
module phy_port_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_wr,
   input logic          req_rd,
   input logic          ack,
   input logic          phy_we,
   input logic          rd_cap,
   input logic [DW-1:0] rbyte
);
   p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (req_wr || req_rd)) |=> ack);

   p_access_then_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_we || rd_cap) |=> ack);

   p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req_wr && !req_rd) |=> !ack);

   p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_we || rd_cap) |=> !(phy_we || rd_cap));

   p_rbyte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cap |=> $stable(rbyte));

   p_no_access_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !(phy_we || rd_cap));
endmodule

bind phy_port_bridge phy_port_chk #(.DW(8)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_wr(port_ctl.wreq), .req_rd(port_ctl.rreq),
   .ack(ack), .phy_we(phy_we), .rd_cap(rd_cap), .rbyte(rbyte_q)
);

// File: tb/tb_phy_port_bridge.sv
module tb_phy_port_bridge;
   localparam int          CLK_PERIOD = 10;
   localparam int          LAT        = 3;
   localparam logic [9:0]  PORT       = 10'h010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b1;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = PORT;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] model [256];
   logic [7:0] last_rd = 8'h00;
   logic       prev_ack = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_port_bridge #(.LATENCY(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic bit impl(input logic [7:0] a);
      return (a <= 8'h08) || (a >= 8'h0B && a <= 8'h0D);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // monitor: pops an expected read byte at the cycle the acknowledge rises
   always @(negedge clk) begin
      #2;
      if (rst_n && bus_sel && !bus_wr && bus_addr == PORT) begin
         if (bus_rdata[26] && !prev_ack && bus_rdata[25] && !bus_rdata[24]) begin
            if (exp_q.size() == 0) begin
               chk("R6 unexpected read", 32'(bus_rdata[23:16]), 32'hFFFF_FFFF);
            end else begin
               chk(tag_q.pop_front(), 32'(bus_rdata[23:16]), 32'(exp_q.pop_front()));
            end
         end
         prev_ack = bus_rdata[26];
      end
   end

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = PORT;
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; #1;
      d = bus_rdata;
      bus_addr = PORT;
   endtask

   task automatic wait_ack(input string req);
      logic [31:0] w;
      int n = 0;
      for (int i = 0; i < 40; i++) begin
         bus_read(PORT, w);
         if (w[26]) break;
         n++;
      end
      chk(req, n, LAT + 1);
   endtask

   task automatic release_req(input logic [31:0] base);
      logic [31:0] w;
      bus_write(PORT, base);
      bus_read(PORT, w);
      bus_read(PORT, w);
      chk("R4 ack low after release", 32'(w[26]), 0);
   endtask

   task automatic access(input bit wr, input bit rd, input logic [7:0] a,
                         input logic [7:0] d, input string req);
      logic [31:0] base, w;
      base = {16'h0, d, a};
      if (rd && !wr) begin
         exp_q.push_back(impl(a) ? model[a] : 8'h00);
         tag_q.push_back(req);
         last_rd = impl(a) ? model[a] : 8'h00;
      end
      bus_write(PORT, base);
      bus_write(PORT, base | (32'(wr) << 24) | (32'(rd) << 25));
      wait_ack(req);
      bus_read(PORT, w);
      chk("R3 ack held", 32'(w[26]), 1);
      release_req(base);
      if (wr && impl(a)) model[a] = d;
   endtask

   initial begin
      logic [31:0] w;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      bus_read(PORT, w);
      chk("R10 port reset", w, 32'h0);
      bus_read(10'h200, w);
      chk("R1 slot window reads 0", w, 32'h0);

      for (int a = 0; a < 14; a++) access(1'b0, 1'b1, 8'(a), 8'h00, "R10 reset value");

      for (int a = 0; a < 14; a++)
         if (impl(8'(a))) access(1'b1, 1'b0, 8'(a), 8'(8'h11 * (a + 1)), "R7 write timing");
      for (int a = 0; a < 14; a++)
         if (impl(8'(a))) access(1'b0, 1'b1, 8'(a), 8'h00, "R7 readback");

      access(1'b1, 1'b0, 8'h09, 8'hA5, "R8 hole write timing");
      access(1'b1, 1'b0, 8'h0A, 8'hA5, "R8 hole write timing");
      access(1'b1, 1'b0, 8'h0E, 8'hA5, "R8 hole write timing");
      access(1'b1, 1'b0, 8'hFF, 8'hA5, "R8 hole write timing");
      access(1'b0, 1'b1, 8'h09, 8'h00, "R8 hole reads 0");
      access(1'b0, 1'b1, 8'h0A, 8'h00, "R8 hole reads 0");
      access(1'b0, 1'b1, 8'hFF, 8'h00, "R8 hole reads 0");

      // R5: change write byte while request held after ack
      bus_write(PORT, 32'h0000_3C01);
      bus_write(PORT, 32'h0100_3C01);
      wait_ack("R5 timing");
      bus_write(PORT, 32'h0100_C301);
      repeat (4) begin
         bus_read(PORT, w);
         chk("R5 ack held with new byte", 32'(w[26]), 1);
      end
      release_req(32'h0000_C301);
      model[1] = 8'h3C;
      access(1'b0, 1'b1, 8'h01, 8'h00, "R5 single write");

      // R6: read-back byte holds through a later write
      access(1'b0, 1'b1, 8'h03, 8'h00, "R6 read");
      access(1'b1, 1'b0, 8'h05, 8'h77, "R6 write");
      bus_read(PORT, w);
      chk("R6 byte held", 32'(w[23:16]), 32'(last_rd));

      // R9: both request bits set -> write
      access(1'b1, 1'b1, 8'h04, 8'h5A, "R9 timing");
      bus_read(PORT, w);
      chk("R9 byte unchanged", 32'(w[23:16]), 32'(last_rd));
      access(1'b0, 1'b1, 8'h04, 8'h00, "R9 wrote");

      // R1: other offsets do not touch the control word
      bus_write(PORT, 32'h0000_2211);
      bus_write(10'h014, 32'h0300_FFFF);
      bus_write(10'h200, 32'h0300_EEEE);
      bus_read(PORT, w);
      chk("R1 port unchanged", w, {8'h00, last_rd, 16'h2211});
      bus_read(10'h014, w);
      chk("R1 other offset reads 0", w, 32'h0);

      // R2: field layout and read-only bits
      bus_write(PORT, 32'hFC00_ABCD);
      bus_read(PORT, w);
      chk("R2 field layout", w, {8'h00, last_rd, 16'hABCD});

      chk("R6 scoreboard drained", 32'(exp_q.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule